// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

A passive monitor that sits beside a four-bank DDR SDRAM command bus and watches the decoded commands. It keeps its own view of which banks hold an open row and counts clock cycles since the events that timing limits are measured from. Every command is compared against those counts, and two deadlines are watched on their own: how long a row may stay open, and how long the bus may go without a refresh. The block never drives the bus and never blocks a command; it only reports.

Each cycle's result is a mask with one bit per rule, so several rules broken in the same cycle are all visible at once. A single-bit flag summarises the mask. Every limit is a parameter counted in clock cycles. The distance between two commands is the number of rising edges from the first to the second, so back-to-back commands are one cycle apart, and a rule fires when the distance is below its limit.

Commands arrive as a 3-bit code with a bank number and an auto-precharge flag. The same flag turns a precharge into an all-bank precharge. A command that breaks a rule still updates the tracked state exactly as the memory would.

Top module: `sdram_timing_checker`

## Requirements
- R1: A READ (code 2) or WRITE (code 3) to a bank with no open row sets mask bit 0 and changes no bank state.
- R2: An ACTIVATE (code 1) to a bank whose row is already open sets bit 1; the bank stays open and its activate time restarts.
- R3: A READ less than T_RCD_RD cycles after the bank's ACTIVATE sets bit 2, and a WRITE less than T_RCD_WR cycles after it sets bit 3; the two limits are applied separately.
- R4: An ACTIVATE less than T_RRD cycles after the previous ACTIVATE sets bit 4 only when that previous ACTIVATE went to a different bank.
- R5: An ACTIVATE less than T_RC cycles after the previous ACTIVATE to the same bank sets bit 5.
- R6: An ACTIVATE less than T_RP cycles after its bank was closed by a PRECHARGE (code 4) or a READ with auto-precharge sets bit 6.
- R7: A PRECHARGE that closes an open bank less than T_WR cycles after that bank's last WRITE sets bit 7.
- R8: After a WRITE with auto-precharge closes a bank, the next ACTIVATE to it sets bit 8 when it comes less than T_DAL cycles after that WRITE; bit 6 is not applied to that ACTIVATE.
- R9: A PRECHARGE (single bank, or all banks when the flag is high) that closes an open bank less than T_RAS cycles after its ACTIVATE sets bit 9; banks already closed are left alone.
- R10: When an open bank reaches exactly T_RAS_MAX cycles since its ACTIVATE and is not closed in that cycle, bit 10 is set, once.
- R11: A MODE-REGISTER write (code 6) while any bank is open or any bank closed less than T_RP cycles earlier sets bit 11; a REFRESH (code 5) with any bank open sets bit 12.
- R12: When exactly T_REFI cycles have passed since the last REFRESH (or since reset) and the current command is not a REFRESH, bit 13 is set, once.
- R13: An ACTIVATE, REFRESH or MODE-REGISTER write less than T_RFC cycles after a REFRESH sets bit 14.
- R14: The mask and flag are registered: a command sampled at one edge is reported after that edge, the flag is the OR of the mask, both are zero in and right after reset, and codes 0 and 7 are no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command code |
| bank | input | $clog2(NB) | Bank addressed by the command |
| ap | input | 1 | Auto-precharge on READ/WRITE, all banks on PRECHARGE |
| viol | output | 1 | Some rule was broken in the reported cycle |
| viol_rules | output | 15 | One bit per rule, as numbered in the requirements |

## Verification
The row-open deadline and the refresh deadline are free-running timers, so they can fall in the cycle where a command breaks its own rule. The bench opens a row exactly T_RAS_MAX cycles before the refresh deadline and issues a READ to a closed bank in that very cycle. It then expects bits 0, 10 and 13 together, and none of them one cycle later. A behavioural model working from absolute cycle numbers predicts the full mask on every clock, so any lost or extra bit in a coincidence is caught.

// File: rtl/sdram_timing_checker.sv
module sdram_timing_checker #(
  parameter int NB        = 4,
  parameter int T_RC      = 21,
  parameter int T_RFC     = 24,
  parameter int T_RAS     = 14,
  parameter int T_RAS_MAX = 100000,
  parameter int T_RCD_RD  = 7,
  parameter int T_RCD_WR  = 5,
  parameter int T_RP      = 7,
  parameter int T_RRD     = 5,
  parameter int T_WR      = 4,
  parameter int T_DAL     = 11,
  parameter int T_REFI    = 3510
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              cmd,
  input  logic [$clog2(NB)-1:0]   bank,
  input  logic                    ap,
  output logic                    viol,
  output logic [14:0]             viol_rules
);

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int BW   = $clog2(NB);
  localparam int SMAX = maxi(maxi(maxi(T_RC, T_RFC), maxi(T_RP, T_RRD)),
                             maxi(maxi(T_WR, T_DAL), maxi(T_RAS, maxi(T_RCD_RD, T_RCD_WR))));
  localparam int SW   = $clog2(SMAX + 1);
  localparam int AW   = $clog2(maxi(T_RAS_MAX, SMAX) + 2);
  localparam int RW   = $clog2(T_REFI + 2);

  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6;

  localparam int R_IDLE = 0, R_ACT_OPEN = 1, R_RCD_RD = 2, R_RCD_WR = 3,
                 R_RRD = 4, R_RC = 5, R_RP = 6, R_WR = 7, R_DAL = 8,
                 R_RAS_MIN = 9, R_RAS_MAX = 10, R_MRS_BUSY = 11,
                 R_REF_BUSY = 12, R_REF_LATE = 13, R_RFC = 14;

  localparam logic [AW-1:0] A_RC = AW'(T_RC), A_RAS = AW'(T_RAS),
                            A_RCD_RD = AW'(T_RCD_RD), A_RCD_WR = AW'(T_RCD_WR),
                            A_RAS_MAX = AW'(T_RAS_MAX);
  localparam logic [SW-1:0] L_RP = SW'(T_RP), L_RRD = SW'(T_RRD), L_WR = SW'(T_WR),
                            L_DAL = SW'(T_DAL), L_RFC = SW'(T_RFC);
  localparam logic [RW-1:0] L_REFI = RW'(T_REFI);

  logic [AW-1:0] act_q [NB];
  logic [SW-1:0] pre_q [NB];
  logic [SW-1:0] wr_q  [NB];
  logic [NB-1:0] open_q, dal_q;
  logic [SW-1:0] rrd_q, rfc_q;
  logic [RW-1:0] refi_q;
  logic [BW-1:0] last_q;

  logic [NB-1:0] sel, cls, tgt, rp_recent;
  logic [14:0]   hit;

  wire is_act = (cmd == C_ACT);
  wire is_rd  = (cmd == C_RD);
  wire is_wr  = (cmd == C_WR);
  wire is_pre = (cmd == C_PRE);
  wire is_ref = (cmd == C_REF);
  wire is_mrs = (cmd == C_MRS);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      sel[i]       = (bank == BW'(i));
      tgt[i]       = open_q[i] && (ap || sel[i]);
      cls[i]       = (is_pre && tgt[i]) || ((is_rd || is_wr) && ap && sel[i] && open_q[i]);
      rp_recent[i] = (pre_q[i] < L_RP);
    end
  end

  always_comb begin
    hit = '0;
    if (is_act) begin
      hit[R_ACT_OPEN] = open_q[bank];
      hit[R_RRD]      = (rrd_q < L_RRD) && (last_q != bank);
      hit[R_RC]       = (act_q[bank] < A_RC);
      if (dal_q[bank]) hit[R_DAL] = (wr_q[bank] < L_DAL);
      else             hit[R_RP]  = (pre_q[bank] < L_RP);
    end
    if (is_rd || is_wr) begin
      hit[R_IDLE] = !open_q[bank];
      if (is_rd) hit[R_RCD_RD] = open_q[bank] && (act_q[bank] < A_RCD_RD);
      else       hit[R_RCD_WR] = open_q[bank] && (act_q[bank] < A_RCD_WR);
    end
    if (is_pre) begin
      for (int i = 0; i < NB; i++) begin
        if (tgt[i] && (act_q[i] < A_RAS)) hit[R_RAS_MIN] = 1'b1;
        if (tgt[i] && (wr_q[i] < L_WR))   hit[R_WR]      = 1'b1;
      end
    end
    hit[R_REF_BUSY] = is_ref && (|open_q);
    hit[R_MRS_BUSY] = is_mrs && ((|open_q) || (|rp_recent));
    hit[R_RFC]      = (is_act || is_ref || is_mrs) && (rfc_q < L_RFC);
    for (int i = 0; i < NB; i++)
      if (open_q[i] && (act_q[i] == A_RAS_MAX) && !cls[i]) hit[R_RAS_MAX] = 1'b1;
    hit[R_REF_LATE] = (refi_q == L_REFI) && !is_ref;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        act_q[i] <= '1;
        pre_q[i] <= '1;
        wr_q[i]  <= '1;
      end
      open_q     <= '0;
      dal_q      <= '0;
      rrd_q      <= '1;
      rfc_q      <= '1;
      refi_q     <= '0;
      last_q     <= '0;
      viol       <= 1'b0;
      viol_rules <= '0;
    end else begin
      rrd_q  <= is_act ? SW'(1) : rrd_q + SW'(~&rrd_q);
      rfc_q  <= is_ref ? SW'(1) : rfc_q + SW'(~&rfc_q);
      refi_q <= is_ref ? RW'(1) : refi_q + RW'(~&refi_q);
      if (is_act) last_q <= bank;
      for (int i = 0; i < NB; i++) begin
        act_q[i] <= (is_act && sel[i]) ? AW'(1) : act_q[i] + AW'(~&act_q[i]);
        pre_q[i] <= cls[i] ? SW'(1) : pre_q[i] + SW'(~&pre_q[i]);
        wr_q[i]  <= (is_wr && sel[i] && open_q[i]) ? SW'(1) : wr_q[i] + SW'(~&wr_q[i]);
        if (is_act && sel[i])      open_q[i] <= 1'b1;
        else if (cls[i])           open_q[i] <= 1'b0;
        if (is_act && sel[i])                      dal_q[i] <= 1'b0;
        else if (is_wr && ap && sel[i] && open_q[i]) dal_q[i] <= 1'b1;
        else if (cls[i])                           dal_q[i] <= 1'b0;
      end
      viol       <= |hit;
      viol_rules <= hit;
    end
  end

endmodule

// File: rtl/sdram_timing_checker_sva.sv
module sdram_timing_checker_sva #(
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            cmd,
  input logic [$clog2(NB)-1:0] bank,
  input logic                  ap,
  input logic                  viol,
  input logic [14:0]           viol_rules,
  input logic [NB-1:0]         open_q
);

  a_r1_rw_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'd2 || cmd == 3'd3) && !open_q[bank]) |=> viol_rules[0]);

  a_r2_act_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && open_q[bank]) |=> viol_rules[1]);

  a_r2_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |=> open_q[$past(bank)]);

  a_r9_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4 && ap) |=> (open_q == '0));

  a_r11_ref_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5 && (|open_q)) |=> viol_rules[12]);

  a_r11_mrs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6 && (|open_q)) |=> viol_rules[11]);

  a_r14_cmd_rules_need_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_rules[9:0] != '0) |-> ($past(cmd) != 3'd0 && $past(cmd) != 3'd7));

  a_r14_flag_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_rules != '0));

endmodule

bind sdram_timing_checker sdram_timing_checker_sva #(.NB(NB)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .ap(ap),
  .viol(viol), .viol_rules(viol_rules), .open_q(open_q)
);

// File: tb/sdram_timing_checker_tb.sv
module sdram_timing_checker_tb;
  localparam int NB = 4, T_RC = 8, T_RFC = 9, T_RAS = 5, T_RAS_MAX = 40,
                 T_RCD_RD = 4, T_RCD_WR = 3, T_RP = 3, T_RRD = 2, T_WR = 3,
                 T_DAL = 6, T_REFI = 300;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, MRS = 3'd6;
  localparam int OLD = -100000;

  logic clk = 1'b0, rst_n = 1'b0, ap = 1'b0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic viol;
  logic [14:0] viol_rules;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sdram_timing_checker #(.NB(NB), .T_RC(T_RC), .T_RFC(T_RFC), .T_RAS(T_RAS),
    .T_RAS_MAX(T_RAS_MAX), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR), .T_RP(T_RP),
    .T_RRD(T_RRD), .T_WR(T_WR), .T_DAL(T_DAL), .T_REFI(T_REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .ap(ap),
    .viol(viol), .viol_rules(viol_rules));

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";  1: return "R2";  2, 3: return "R3"; 4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";    8: return "R8";
      9: return "R9";  10: return "R10"; 11, 12: return "R11";
      13: return "R12"; default: return "R13";
    endcase
  endfunction

  // behavioural reference: absolute cycle numbers of past events
  int k, t_act[NB], t_cls[NB], t_wr[NB], t_any, last_b, t_rfc, t_refi;
  bit opn[NB], dal[NB], live = 0;
  logic [14:0] exp_mask = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; t_any = OLD; last_b = 0; t_rfc = OLD; t_refi = 0;
      for (int i = 0; i < NB; i++) begin
        t_act[i] = OLD; t_cls[i] = OLD; t_wr[i] = OLD; opn[i] = 0; dal[i] = 0;
      end
      exp_mask = '0; live = 0;
    end else begin
      logic [14:0] h;
      bit cl[NB];
      int b;
      h = '0; b = bank;
      for (int i = 0; i < NB; i++)
        cl[i] = opn[i] && ((cmd == PRE && (ap || b == i)) || ((cmd == RD || cmd == WR) && ap && b == i));
      if (cmd == ACT) begin
        h[1] = opn[b];
        h[4] = (k - t_any < T_RRD) && (last_b != b);
        h[5] = (k - t_act[b] < T_RC);
        if (dal[b]) h[8] = (k - t_wr[b] < T_DAL); else h[6] = (k - t_cls[b] < T_RP);
      end
      if (cmd == RD || cmd == WR) begin
        h[0] = !opn[b];
        if (opn[b] && cmd == RD && k - t_act[b] < T_RCD_RD) h[2] = 1;
        if (opn[b] && cmd == WR && k - t_act[b] < T_RCD_WR) h[3] = 1;
      end
      for (int i = 0; i < NB; i++) begin
        if (cmd == PRE && cl[i] && k - t_act[i] < T_RAS) h[9] = 1;
        if (cmd == PRE && cl[i] && k - t_wr[i] < T_WR) h[7] = 1;
        if (cmd == REF && opn[i]) h[12] = 1;
        if (cmd == MRS && (opn[i] || k - t_cls[i] < T_RP)) h[11] = 1;
        if (opn[i] && k - t_act[i] == T_RAS_MAX && !cl[i]) h[10] = 1;
      end
      if ((cmd == ACT || cmd == REF || cmd == MRS) && k - t_rfc < T_RFC) h[14] = 1;
      if (k - t_refi == T_REFI && cmd != REF) h[13] = 1;
      if (cmd == WR && opn[b]) begin
        t_wr[b] = k;
        if (ap) dal[b] = 1;
      end
      for (int i = 0; i < NB; i++)
        if (cl[i]) begin
          opn[i] = 0; t_cls[i] = k;
          if (!(cmd == WR && ap)) dal[i] = 0;
        end
      if (cmd == ACT) begin
        t_any = k; last_b = b; opn[b] = 1; t_act[b] = k; dal[b] = 0;
      end
      if (cmd == REF) begin t_rfc = k; t_refi = k; end
      exp_mask = h; k++; live = 1;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      total++;
      if (viol_rules !== exp_mask || viol !== (exp_mask != 0)) begin
        bad++;
        for (int i = 0; i < 15; i++)
          if (viol_rules[i] !== exp_mask[i])
            $display("FAIL %s cycle %0d bit %0d: got %b exp %b", tag_of(i), k, i, viol_rules[i], exp_mask[i]);
        if (viol !== (exp_mask != 0))
          $display("FAIL R14 cycle %0d flag: got %b exp %b", k, viol, exp_mask != 0);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input int b, input logic a);
    cmd = c; bank = b[1:0]; ap = a;
    @(negedge clk);
    cmd = NOP; ap = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bit(input int i, input logic e, input string tag);
    total++;
    if (viol_rules[i] !== e) begin
      bad++;
      $display("FAIL %s bit %0d: got %b exp %b", tag, i, viol_rules[i], e);
    end
  endtask

  task automatic chk_clean(input string tag);
    total++;
    if (viol !== 1'b0 || viol_rules !== '0) begin
      bad++;
      $display("FAIL %s clean: got %b/%h exp 0/0000", tag, viol, viol_rules);
    end
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk_clean("R14 reset");
    rst_n = 1'b1;
    idle(1);
    chk_clean("R14 after reset");
    issue(RD, 0, 0);  chk_bit(0, 1, "R1");
    idle(2);
    issue(ACT, 0, 0); chk_bit(0, 0, "R1");
    idle(2);
    issue(RD, 0, 0);  chk_bit(2, 1, "R3");
    issue(WR, 0, 0);  chk_bit(3, 0, "R3");
    issue(ACT, 0, 0); chk_bit(1, 1, "R2"); chk_bit(5, 1, "R5"); chk_bit(4, 0, "R4");
    issue(ACT, 1, 0); chk_bit(4, 1, "R4");
    idle(1);
    issue(ACT, 2, 0); chk_bit(4, 0, "R4");
    idle(1);
    issue(WR, 2, 0);  chk_bit(3, 1, "R3");
    idle(10);
    issue(WR, 0, 0);  chk_bit(3, 0, "R3");
    issue(PRE, 0, 0); chk_bit(7, 1, "R7"); chk_bit(9, 0, "R9");
    issue(ACT, 0, 0); chk_bit(6, 1, "R6");
    issue(PRE, 0, 0); chk_bit(9, 1, "R9");
    idle(3);
    issue(ACT, 3, 0); chk_bit(4, 0, "R4");
    idle(2);
    issue(WR, 3, 1);  chk_bit(3, 0, "R3");
    idle(2);
    issue(ACT, 3, 0); chk_bit(8, 1, "R8"); chk_bit(6, 0, "R8");
    issue(REF, 0, 0); chk_bit(12, 1, "R11");
    issue(MRS, 0, 0); chk_bit(11, 1, "R11"); chk_bit(14, 1, "R13");
    issue(PRE, 0, 1);
    idle(8);
    issue(REF, 0, 0); chk_clean("R11 R13 refresh when idle");
    idle(259);
    issue(ACT, 0, 0);
    idle(39);
    issue(RD, 1, 0);  chk_bit(0, 1, "R1"); chk_bit(10, 1, "R10"); chk_bit(13, 1, "R12");
    idle(1);          chk_bit(10, 0, "R10"); chk_bit(13, 0, "R12");
    issue(PRE, 0, 0);
    idle(3);
    issue(MRS, 0, 0); chk_clean("R11 mode write when idle");
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule